// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers twenty-eight interrupt sources and turns them into two requests for a processor core: a fast request and a normal request. One dedicated fast pin and eight general pins arrive from outside the chip, are active low, and are treated as asynchronous. Nineteen request lines come from on-chip peripherals and are already synchronous. Every source latches its events into a pending flag. Each source also holds a three-bit priority level, and level 0 switches the source off.

The normal request path picks the pending, enabled source with the highest level and shows its number on `intNum`. It raises `irqReq` only while that level is strictly above the level now in service. When the core acknowledges, the winner's pending flag is cleared and the service level rises to the winner's level. The previous level is saved on a small stack, and an end-of-interrupt strobe restores it. The fast pin never uses the normal path. It raises `fiqReq` on its own, whatever level is in service, and a separate acknowledge clears it. Priorities are written one source at a time through a simple write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irqReq`, `fiqReq` and `intNum` are 0, `curLevel` is 0, every source level is 0 and no pending flag is set.
- R2: The external pins are active low and pass through a two-flop synchronizer. A falling edge sets the pending flag at the third rising clock edge, counting the first edge that samples the pin low. A pin held low sets the flag only once.
- R3: A rising edge on a peripheral request line sets that source's pending flag at the same clock edge that first samples the line high.
- R4: Source numbers are fixed: 0 is the fast pin, 1 to 8 are general pins 0 to 7, and 9 to 27 are peripheral lines 0 to 18. Source 0 never appears on `intNum` or drives `irqReq`. `fiqReq` is high while source 0 is pending with a nonzero level, whatever `curLevel` holds. `fastAck` clears source 0.
- R5: A source at level 0 never wins. Its events are still latched, and the source competes as soon as a nonzero level is written.
- R6: Among pending sources with a nonzero level, the highest level wins and a tie goes to the lowest source number. `intNum` shows the winner, or 0 when there is none.
- R7: `irqReq` is high only while a winner exists and its level is strictly above `curLevel`.
- R8: An `ackStb` while `irqReq` is high clears the winner's pending flag, pushes `curLevel` onto the stack and loads the winner's level. An `ackStb` while `irqReq` is low has no effect.
- R9: An `eoiStb` restores the last pushed level. With an empty stack it leaves `curLevel` at 0. It is ignored in a cycle where an acknowledge takes effect.
- R10: If a new event arrives in the same cycle that an acknowledge clears the flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastPinN | input | 1 | Dedicated fast interrupt pin, active low, asynchronous |
| gpPinN | input | 8 | General interrupt pins, active low, asynchronous |
| periphReq | input | 19 | Peripheral request lines, synchronous, rising edge triggers |
| cfgWr | input | 1 | Write strobe for one source's priority level |
| cfgSel | input | 5 | Source number being written |
| cfgLevel | input | 3 | New priority level (0 = disabled) |
| ackStb | input | 1 | Acknowledge of the source shown on intNum |
| eoiStb | input | 1 | End of interrupt, restores the previous level |
| fastAck | input | 1 | Clears the fast source's pending flag |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |
| intNum | output | 5 | Number of the winning source |
| curLevel | output | 3 | Priority level now in service |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, an eight-entry level stack and the full set of twenty-eight sources. With these values it can observe the exact three-edge pin latency. It can also nest several service levels, so that popping a level brings back a masked source. Ties are checked between two peripheral sources of equal level. The fast pin is checked while the normal path is masked at the top level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_GP_PINS = 8;
  localparam int unsigned NUM_PERIPH  = 19;
  localparam int unsigned NUM_SRC     = 1 + NUM_GP_PINS + NUM_PERIPH;
  localparam int unsigned SRC_ID_W    = $clog2(NUM_SRC);
  localparam int unsigned LVL_W       = 3;

  typedef logic [SRC_ID_W-1:0] srcId_t;
  typedef logic [LVL_W-1:0]    level_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   clrWin;   // clear pending flag of clrIdx
    srcId_t clrIdx;
    logic   clrFast;  // clear pending flag of the fast source
  } ctlStb_t;
endpackage

// File: rtl/irq_dp.sv
module irq_dp
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_GP_PINS:0]   pinN,       // bit 0 is the fast pin
  input  logic [NUM_PERIPH-1:0]  periphReq,
  input  logic                   cfgWr,
  input  srcId_t                 cfgSel,
  input  level_t                 cfgLevel,
  input  ctlStb_t                stb,
  output logic                   winValid,
  output srcId_t                 winIdx,
  output level_t                 winLevel,
  output logic                   fastReq
);
  localparam int unsigned NUM_PINS = NUM_GP_PINS + 1;

  logic [NUM_PINS-1:0]   syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0]   pinPrev;
  logic [NUM_PINS-1:0]   pinFall;
  logic [NUM_PERIPH-1:0] periphPrev;
  logic [NUM_PERIPH-1:0] periphRise;
  logic [NUM_SRC-1:0]    setVec;
  logic [NUM_SRC-1:0]    clrVec;
  logic [NUM_SRC-1:0]    pending;
  level_t                lvlTab [NUM_SRC];

  // synchronizer chain for the asynchronous pins, idle high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
      pinPrev <= '1;
    end else begin
      syncQ[0] <= pinN;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      pinPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) periphPrev <= '0;
    else       periphPrev <= periphReq;
  end

  assign pinFall    = pinPrev & ~syncQ[SYNC_STAGES-1];
  assign periphRise = periphReq & ~periphPrev;
  assign setVec     = {periphRise, pinFall};

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      clrVec[i] = stb.clrWin && (stb.clrIdx == SRC_ID_W'(i));
    end
    if (stb.clrFast) clrVec[0] = 1'b1;
  end

  // a fresh event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clrVec) | setVec;
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gLvl
      always_ff @(posedge clk) begin
        if (!rstN)
          lvlTab[g] <= '0;
        else if (cfgWr && cfgSel == SRC_ID_W'(g))
          lvlTab[g] <= cfgLevel;
      end
    end
  endgenerate

  // resolver: highest level, lowest number on ties; source 0 excluded
  always_comb begin
    winLevel = '0;
    winIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (pending[i] && lvlTab[i] != '0 && lvlTab[i] >= winLevel) begin
        winLevel = lvlTab[i];
        winIdx   = SRC_ID_W'(i);
      end
    end
    winValid = (winLevel != '0);
  end

  assign fastReq = pending[0] && (lvlTab[0] != '0);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ackStb,
  input  logic    eoiStb,
  input  logic    fastAck,
  input  logic    winValid,
  input  srcId_t  winIdx,
  input  level_t  winLevel,
  output ctlStb_t stb,
  output logic    irqReq,
  output level_t  curLevel
);
  localparam int unsigned PTR_W = $clog2(STACK_DEPTH + 1);
  localparam int unsigned IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  level_t           lvlStack [STACK_DEPTH];
  logic [PTR_W-1:0] stackPtr;
  logic [PTR_W-1:0] ptrM1;
  logic             stackFull;
  logic             stackEmpty;
  logic             doAck;
  logic             doEoi;

  assign stackFull  = (stackPtr == PTR_W'(STACK_DEPTH));
  assign stackEmpty = (stackPtr == '0);
  assign ptrM1      = stackPtr - PTR_W'(1);

  assign irqReq = winValid && (winLevel > curLevel);
  assign doAck  = ackStb && irqReq && !stackFull;
  assign doEoi  = eoiStb && !doAck && !stackEmpty;

  always_comb begin
    stb.clrWin  = doAck;
    stb.clrIdx  = winIdx;
    stb.clrFast = fastAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackPtr <= '0;
      curLevel <= '0;
      for (int d = 0; d < STACK_DEPTH; d++) lvlStack[d] <= '0;
    end else if (doAck) begin
      lvlStack[stackPtr[IDX_W-1:0]] <= curLevel;
      stackPtr <= stackPtr + PTR_W'(1);
      curLevel <= winLevel;
    end else if (doEoi) begin
      curLevel <= lvlStack[ptrM1[IDX_W-1:0]];
      stackPtr <= ptrM1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fastPinN,
  input  logic [NUM_GP_PINS-1:0] gpPinN,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic                  cfgWr,
  input  logic [SRC_ID_W-1:0]   cfgSel,
  input  logic [LVL_W-1:0]      cfgLevel,
  input  logic                  ackStb,
  input  logic                  eoiStb,
  input  logic                  fastAck,
  output logic                  irqReq,
  output logic                  fiqReq,
  output logic [SRC_ID_W-1:0]   intNum,
  output logic [LVL_W-1:0]      curLevel
);
  ctlStb_t stb;
  logic    winValid;
  srcId_t  winIdx;
  level_t  winLevel;

  irq_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN),
    .pinN({gpPinN, fastPinN}),
    .periphReq(periphReq),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgLevel(cfgLevel),
    .stb(stb),
    .winValid(winValid), .winIdx(winIdx), .winLevel(winLevel),
    .fastReq(fiqReq)
  );

  irq_ctl #(.STACK_DEPTH(STACK_DEPTH)) i_ctl (
    .clk(clk), .rstN(rstN),
    .ackStb(ackStb), .eoiStb(eoiStb), .fastAck(fastAck),
    .winValid(winValid), .winIdx(winIdx), .winLevel(winLevel),
    .stb(stb), .irqReq(irqReq), .curLevel(curLevel)
  );

  assign intNum = winIdx;
endmodule

// File: rtl/irq_chk.sv
module irq_chk
  import irq_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   ackStb,
  input logic   eoiStb,
  input logic   irqReq,
  input srcId_t intNum,
  input level_t curLevel,
  input level_t winLevel
);
  // R4: the fast source never travels on the normal path
  a_r4_irq_never_fast: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> intNum != '0);

  // R8: an effective acknowledge loads the winner's level
  a_r8_ack_loads_level: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqReq) |=> curLevel == $past(winLevel));

  // R7: service level only climbs on acknowledge
  a_r7_level_rises: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqReq) |=> curLevel > $past(curLevel));

  // R9: end of interrupt on an empty stack keeps level 0
  a_r9_eoi_empty: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStb && !ackStb && curLevel == '0) |=> curLevel == '0);

  // R9: popping never raises the level
  a_r9_eoi_lowers: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStb && !(ackStb && irqReq)) |=> curLevel <= $past(curLevel));

  // R8: without strobes the service level holds
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ackStb && !eoiStb) |=> $stable(curLevel));
endmodule

bind prio_irq_ctrl irq_chk i_chk (
  .clk(clk), .rstN(rstN), .ackStb(ackStb), .eoiStb(eoiStb),
  .irqReq(irqReq), .intNum(intNum), .curLevel(curLevel), .winLevel(winLevel)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fastPinN = 1'b1;
  logic [7:0]  gpPinN = '1;
  logic [18:0] periphReq = '0;
  logic        cfgWr = 1'b0;
  logic [4:0]  cfgSel = '0;
  logic [2:0]  cfgLevel = '0;
  logic        ackStb = 1'b0;
  logic        eoiStb = 1'b0;
  logic        fastAck = 1'b0;
  logic        irqReq, fiqReq;
  logic [4:0]  intNum;
  logic [2:0]  curLevel;

  int chkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .fastPinN(fastPinN), .gpPinN(gpPinN),
    .periphReq(periphReq), .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgLevel(cfgLevel),
    .ackStb(ackStb), .eoiStb(eoiStb), .fastAck(fastAck),
    .irqReq(irqReq), .fiqReq(fiqReq), .intNum(intNum), .curLevel(curLevel)
  );

  always #4 clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int lvl);
    cfgWr = 1'b1; cfgSel = 5'(idx); cfgLevel = 3'(lvl);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic ack();
    ackStb = 1'b1; @(negedge clk); ackStb = 1'b0;
  endtask

  task automatic eoi();
    eoiStb = 1'b1; @(negedge clk); eoiStb = 1'b0;
  endtask

  task automatic pulsePeriph(input int j);
    periphReq[j] = 1'b1; @(negedge clk); periphReq[j] = 1'b0;
  endtask

  task automatic pulseGp(input int p);
    gpPinN[p] = 1'b0;
    repeat (2) @(negedge clk);
    gpPinN[p] = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 irqReq", irqReq, 0);
    check("R1 fiqReq", fiqReq, 0);
    check("R1 intNum", intNum, 0);
    check("R1 curLevel", curLevel, 0);
  endtask

  task automatic testDisabledThenEnabled();
    pulsePeriph(4);                       // source 13, level 0
    check("R5 disabled no irq", irqReq, 0);
    check("R5 disabled intNum", intNum, 0);
    cfg(13, 3);
    check("R5 R3 enabled irq", irqReq, 1);
    check("R3 intNum", intNum, 13);
  endtask

  task automatic testPriorityNesting();
    cfg(15, 3);
    pulsePeriph(6);                       // source 15, same level as 13
    check("R6 tie lowest number", intNum, 13);
    cfg(3, 5);
    pulseGp(2);                           // source 3
    check("R6 higher level wins", intNum, 3);
    check("R7 irq above level 0", irqReq, 1);
    ack();
    check("R8 curLevel after ack", curLevel, 5);
    check("R8 pending cleared", intNum, 13);
    check("R7 masked lower level", irqReq, 0);
    ack();
    check("R8 ack ignored when idle", curLevel, 5);
    eoi();
    check("R9 pop to 0", curLevel, 0);
    check("R7 unmasked", irqReq, 1);
    check("R9 winner after pop", intNum, 13);
    ack();
    check("R8 level 3", curLevel, 3);
    check("R7 equal level masked", irqReq, 0);
    check("R6 next winner", intNum, 15);
    eoi();
    check("R7 irq again", irqReq, 1);
    ack();
    check("R8 pending 15 cleared", intNum, 0);
    eoi();
    eoi();
    check("R9 eoi on empty", curLevel, 0);
    check("R7 nothing pending", irqReq, 0);
  endtask

  task automatic testHeldPin();
    cfg(1, 2);
    gpPinN[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 not yet after two edges", irqReq, 0);
    @(negedge clk);
    check("R2 set at third edge", irqReq, 1);
    check("R2 R4 intNum of pin 0", intNum, 1);
    ack();
    check("R8 level 2", curLevel, 2);
    eoi();
    repeat (4) @(negedge clk);
    check("R2 held low no retrigger", irqReq, 0);
    check("R2 held low intNum", intNum, 0);
    gpPinN[0] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic testFast();
    cfg(20, 7);
    pulsePeriph(11);
    ack();
    check("R8 level 7", curLevel, 7);
    cfg(0, 1);
    fastPinN = 1'b0;
    repeat (2) @(negedge clk);
    fastPinN = 1'b1;
    @(negedge clk);
    check("R4 fiq regardless of level", fiqReq, 1);
    check("R4 no irq for fast pin", irqReq, 0);
    check("R4 fast never on intNum", intNum, 0);
    fastAck = 1'b1; @(negedge clk); fastAck = 1'b0;
    check("R4 fastAck clears", fiqReq, 0);
    eoi();
    check("R9 back to 0", curLevel, 0);
  endtask

  task automatic testSetBeatsClear();
    cfg(9, 4);
    periphReq[0] = 1'b1;
    @(negedge clk);
    periphReq[0] = 1'b0;
    check("R3 intNum 9", intNum, 9);
    @(negedge clk);
    ackStb = 1'b1; periphReq[0] = 1'b1;
    @(negedge clk);
    ackStb = 1'b0; periphReq[0] = 1'b0;
    check("R10 level 4", curLevel, 4);
    check("R10 still pending", intNum, 9);
    check("R7 masked equal", irqReq, 0);
    cfg(22, 6);
    pulsePeriph(13);
    check("R7 higher preempts", irqReq, 1);
    check("R6 intNum 22", intNum, 22);
    ackStb = 1'b1; eoiStb = 1'b1;
    @(negedge clk);
    ackStb = 1'b0; eoiStb = 1'b0;
    check("R9 eoi ignored with ack", curLevel, 6);
    eoi();
    check("R9 pop to 4", curLevel, 4);
    check("R7 9 masked at 4", irqReq, 0);
    eoi();
    check("R9 pop to 0", curLevel, 0);
    check("R10 retained event", intNum, 9);
    ack();
    eoi();
    check("R8 all served", intNum, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabledThenEnabled();
    testPriorityNesting();
    testHeldPin();
    testFast();
    testSetBeatsClear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
      $finish;
    end
  end
endmodule